// File: doc/BRIEF.md
# Four-line I2S capture to eight-slot TDM bridge

The bridge collects audio from four stereo I2S converter lines and sends it out as a single TDM stream with eight 24-bit slots per frame. The bit clock and frame pulse come from the TDM side. The bridge divides the bit clock by three to produce the I2S bit clock and the word clock that it drives to the converters. Each frame therefore spans 192 TDM bit clocks and 64 I2S bit clocks.

Each I2S channel arrives as a 32-bit word. Only its 24 most significant bits are stored. Two frame stores alternate. One fills with the frame currently arriving while the other is shifted out, so the output lags the input by exactly one sample period. The role of each store flips at every frame boundary. That boundary is marked by the frame pulse. When a pulse is missing, the bridge's own frame counter marks the boundary instead. A frame that did not fill completely is sent as silence.

Top module: `i2s_tdm_bridge`

## Requirements
- R1: Count TDM bit clocks from the rising edge that samples the frame pulse, taking that edge as count 0. `i2s_bclk` is high exactly after the rising edges whose count modulo 3 equals 2, and low after all others. This gives 64 I2S bit clocks per frame.
- R2: Number the I2S bit periods of a frame b = 0..63, where b = count / 3. `i2s_ws` is high (right channel) during periods 31 to 62 and low during all others. It changes only while `i2s_bclk` is low, one I2S bit period ahead of the channel it announces.
- R3: Each line is sampled on the rising edge of `i2s_bclk`. Period b carries bit 31 − (b mod 32) of the left word when b < 32, and of the right word otherwise. The MSB comes first.
- R4: Line n carries the left channel into TDM slot 2n and the right channel into TDM slot 2n+1, for n = 0..3.
- R5: A TDM slot holds bits 31..8 of its I2S word. Bits 7..0 have no effect on the output.
- R6: `tdm_dout` changes on the falling edge of the bit clock. The bit for count j is slot j/24, bit 23 − (j mod 24). Slot 0's MSB is therefore driven on the falling edge right after the frame-pulse edge.
- R7: A frame captured during frame period f is transmitted during frame period f+1. The stores swap only at a frame boundary.
- R8: Before the first frame pulse after reset, `tdm_dout` is 0. During the frame period that begins at that first pulse, `tdm_dout` is also 0.
- R9: A frame pulse that arrives before a full frame has been counted realigns all counters. The incomplete frame is then transmitted as all zeros, and the next complete frame is transmitted normally.
- R10: After the first frame pulse, a missing pulse changes nothing. The internal count wraps after 192 bit clocks, and the swap and capture go on as if the pulse had been present.
- R11: While reset is asserted, `i2s_bclk`, `i2s_ws` and `tdm_dout` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | TDM bit clock, supplied externally |
| rst_n | input | 1 | Asynchronous reset, active low |
| tdm_fs | input | 1 | Frame pulse, high for one bit clock before slot 0 |
| i2s_din | input | 4 | One serial data line per stereo I2S converter |
| i2s_bclk | output | 1 | I2S bit clock, TDM bit clock divided by 3 |
| i2s_ws | output | 1 | I2S word clock, high for the right channel |
| tdm_dout | output | 1 | TDM serial data, eight 24-bit slots |

## Verification
The visible effects of an internal fault differ in how quickly they appear.

- **Divider or word-clock counters:** a slip shows on `i2s_bclk` or `i2s_ws` within one I2S bit period of the frame pulse. The bench compares both against the expected shape at every bit clock of every aligned frame.
- **Write position in a store:** a misplaced bit, a wrong slot for a line, or a lost truncation boundary only appears one frame later, as a wrong bit in the serialized slot.
- **Store-select or silence flag:** a wrong value appears either as stale data repeated for a whole frame or as data where silence is required. The frames that follow the first pulse, an early pulse and a missing pulse expose these cases within one frame period.

// File: rtl/i2st_pkg.sv
package i2st_pkg;

   typedef enum logic {
      SIDE_LEFT  = 1'b0,
      SIDE_RIGHT = 1'b1
   } side_e;

   function automatic int unsigned frame_clocks(int unsigned slots, int unsigned slot_w);
      return slots * slot_w;
   endfunction

endpackage

// File: rtl/i2st_timing.sv
module i2st_timing #(
   parameter int unsigned I2S_W  = 32,
   parameter int unsigned SLOT_W = 24,
   parameter int unsigned SLOTS  = 8,
   parameter int unsigned DIV    = 3,
   localparam int unsigned BITS  = 2 * I2S_W,
   localparam int unsigned BW    = $clog2(BITS),
   localparam int unsigned PW    = $clog2(DIV),
   localparam int unsigned SW    = $clog2(SLOTS),
   localparam int unsigned QW    = $clog2(SLOT_W)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          fs,
   output logic          bclk_o,
   output logic          ws_o,
   output logic          cap_o,
   output logic [BW-1:0] cap_idx_o,
   output logic [SW-1:0] slot_o,
   output logic [QW-1:0] bpos_o,
   output logic          swap_o,
   output logic          tx_zero_o
);

   localparam logic [PW-1:0] P_LAST = PW'(DIV - 1);
   localparam logic [PW-1:0] P_CAP  = PW'(DIV - 2);
   localparam logic [BW-1:0] B_LAST = BW'(BITS - 1);
   localparam logic [BW-1:0] WS_ON  = BW'(I2S_W - 1);
   localparam logic [BW-1:0] WS_OFF = BW'(BITS - 2);
   localparam logic [SW-1:0] S_LAST = SW'(SLOTS - 1);
   localparam logic [QW-1:0] Q_LAST = QW'(SLOT_W - 1);

   logic [PW-1:0] ph_q, ph_n;
   logic [BW-1:0] bit_q, bit_n;
   logic [SW-1:0] slot_q, slot_n;
   logic [QW-1:0] bpos_q, bpos_n;
   logic          locked_q, bclk_q, ws_q, zero_q;
   logic          at_end;

   always_comb begin
      at_end = (bit_q == B_LAST) && (ph_q == P_LAST);
      if (fs) begin
         ph_n   = '0;
         bit_n  = '0;
         slot_n = '0;
         bpos_n = '0;
      end else begin
         ph_n   = (ph_q == P_LAST) ? '0 : ph_q + 1'b1;
         bit_n  = (ph_q != P_LAST) ? bit_q : ((bit_q == B_LAST) ? '0 : bit_q + 1'b1);
         bpos_n = (bpos_q == Q_LAST) ? '0 : bpos_q + 1'b1;
         slot_n = (bpos_q != Q_LAST) ? slot_q : ((slot_q == S_LAST) ? '0 : slot_q + 1'b1);
      end
   end

   assign swap_o = fs || (locked_q && at_end);
   assign cap_o  = (ph_q == P_CAP) && !fs && locked_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q     <= '0;
         bit_q    <= '0;
         slot_q   <= '0;
         bpos_q   <= '0;
         locked_q <= 1'b0;
         bclk_q   <= 1'b0;
         ws_q     <= 1'b0;
         zero_q   <= 1'b1;
      end else begin
         ph_q     <= ph_n;
         bit_q    <= bit_n;
         slot_q   <= slot_n;
         bpos_q   <= bpos_n;
         locked_q <= locked_q | fs;
         bclk_q   <= (ph_n == P_LAST);
         ws_q     <= (bit_n >= WS_ON) && (bit_n <= WS_OFF);
         if (swap_o) zero_q <= !(locked_q && at_end);
      end
   end

   assign bclk_o    = bclk_q;
   assign ws_o      = ws_q;
   assign cap_idx_o = bit_q;
   assign slot_o    = slot_q;
   assign bpos_o    = bpos_q;
   assign tx_zero_o = zero_q;

   AST_BCLK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bclk_q) |=> !bclk_q);                            // R1
   AST_WS_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ws_q) |-> !bclk_q);                           // R2
   AST_CAP_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      cap_o |=> bclk_q);                                     // R3

endmodule

// File: rtl/i2st_capture.sv
module i2st_capture
   import i2st_pkg::*;
#(
   parameter int unsigned LINES  = 4,
   parameter int unsigned I2S_W  = 32,
   parameter int unsigned SLOT_W = 24,
   localparam int unsigned SLOTS = 2 * LINES,
   localparam int unsigned K     = $clog2(I2S_W),
   localparam int unsigned BW    = K + 1,
   localparam int unsigned SW    = $clog2(SLOTS),
   localparam int unsigned QW    = $clog2(SLOT_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] din,
   input  logic             cap,
   input  logic [BW-1:0]    cap_idx,
   input  logic             swap,
   input  logic [SW-1:0]    slot,
   input  logic [QW-1:0]    bpos,
   output logic             rd_bit
);

   logic          rsel_q;
   logic          keep;
   side_e         wside;
   logic [QW-1:0] wpos, rpos;
   logic [1:0]    lb [LINES];

   assign keep  = {1'b0, cap_idx[K-1:0]} < (K+1)'(SLOT_W);
   assign wside = side_e'(cap_idx[K]);
   assign wpos  = QW'(SLOT_W - 1) - QW'(cap_idx[K-1:0]);
   assign rpos  = QW'(SLOT_W - 1) - bpos;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rsel_q <= 1'b0;
      else if (swap) rsel_q <= !rsel_q;
   end

   for (genvar n = 0; n < LINES; n++) begin : g_line
      logic [SLOT_W-1:0] mem [2][2];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int b = 0; b < 2; b++)
               for (int s = 0; s < 2; s++) mem[b][s] <= '0;
         end else if (cap && keep) begin
            mem[!rsel_q][wside][wpos] <= din[n];
         end
      end
      assign lb[n] = {mem[rsel_q][SIDE_RIGHT][rpos], mem[rsel_q][SIDE_LEFT][rpos]};
   end

   assign rd_bit = lb[slot[SW-1:1]][slot[0]];

   AST_SWAP_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rsel_q) |-> (slot == '0 && bpos == '0));      // R7

endmodule

// File: rtl/i2st_tdm_tx.sv
module i2st_tdm_tx (
   input  logic clk,
   input  logic rst_n,
   input  logic tx_zero,
   input  logic rd_bit,
   output logic dout
);

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) dout <= 1'b0;
      else        dout <= tx_zero ? 1'b0 : rd_bit;
   end

   AST_DOUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_zero && $past(tx_zero)) |-> !dout);                // R8

endmodule

// File: rtl/i2s_tdm_bridge.sv
module i2s_tdm_bridge
   import i2st_pkg::*;
#(
   parameter int unsigned LINES  = 4,
   parameter int unsigned I2S_W  = 32,
   parameter int unsigned SLOT_W = 24,
   parameter int unsigned DIV    = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tdm_fs,
   input  logic [LINES-1:0] i2s_din,
   output logic             i2s_bclk,
   output logic             i2s_ws,
   output logic             tdm_dout
);

   localparam int unsigned SLOTS = 2 * LINES;
   localparam int unsigned BW    = $clog2(2 * I2S_W);
   localparam int unsigned SW    = $clog2(SLOTS);
   localparam int unsigned QW    = $clog2(SLOT_W);

   if (frame_clocks(SLOTS, SLOT_W) != 2 * I2S_W * DIV) begin : g_bad_ratio
      $error("slot clocks per frame must equal I2S clocks times divider");
   end
   if (DIV < 2) begin : g_bad_div
      $error("divider must be at least 2");
   end
   if (SLOT_W > I2S_W) begin : g_bad_width
      $error("TDM slot wider than I2S word");
   end
   if ((1 << $clog2(I2S_W)) != I2S_W) begin : g_bad_word
      $error("I2S word length must be a power of two");
   end

   logic          cap, swap, tx_zero, rd_bit;
   logic [BW-1:0] cap_idx;
   logic [SW-1:0] slot;
   logic [QW-1:0] bpos;

   i2st_timing #(.I2S_W(I2S_W), .SLOT_W(SLOT_W), .SLOTS(SLOTS), .DIV(DIV)) u_timing (
      .clk       (clk),
      .rst_n     (rst_n),
      .fs        (tdm_fs),
      .bclk_o    (i2s_bclk),
      .ws_o      (i2s_ws),
      .cap_o     (cap),
      .cap_idx_o (cap_idx),
      .slot_o    (slot),
      .bpos_o    (bpos),
      .swap_o    (swap),
      .tx_zero_o (tx_zero)
   );

   i2st_capture #(.LINES(LINES), .I2S_W(I2S_W), .SLOT_W(SLOT_W)) u_capture (
      .clk     (clk),
      .rst_n   (rst_n),
      .din     (i2s_din),
      .cap     (cap),
      .cap_idx (cap_idx),
      .swap    (swap),
      .slot    (slot),
      .bpos    (bpos),
      .rd_bit  (rd_bit)
   );

   i2st_tdm_tx u_tx (
      .clk     (clk),
      .rst_n   (rst_n),
      .tx_zero (tx_zero),
      .rd_bit  (rd_bit),
      .dout    (tdm_dout)
   );

endmodule

// File: tb/sim_i2s_tdm_bridge.sv
module sim_i2s_tdm_bridge;

   localparam int SLOTS = 8;
   localparam int FR    = 192;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       fs = 1'b0;
   logic [3:0] din = '0;
   logic       bclk, ws, dout;

   always #4 clk = ~clk;

   i2s_tdm_bridge u0 (
      .clk      (clk),
      .rst_n    (rst_n),
      .tdm_fs   (fs),
      .i2s_din  (din),
      .i2s_bclk (bclk),
      .i2s_ws   (ws),
      .tdm_dout (dout)
   );

   int           n_cmp = 0;
   int           n_bad = 0;
   bit           finished = 1'b0;
   logic [31:0]  wd [SLOTS];
   logic [191:0] rx, sent_prev, expect_now;
   int           clk_err;

   function automatic logic [191:0] pack24();
      logic [191:0] v = '0;
      for (int s = 0; s < SLOTS; s++) v[191-24*s -: 24] = wd[s][31:8];
      return v;
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [191:0] act, input logic [191:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic fill(input logic [31:0] seed);
      for (int s = 0; s < SLOTS; s++)
         wd[s] = seed ^ {4{8'(s * 37 + 11)}};
   endtask

   // one frame period; result in rx, expected data of the previous frame in expect_now
   task automatic run_frame(input bit send_fs, input int len, input bit chk_clk);
      clk_err    = 0;
      rx         = '0;
      expect_now = sent_prev;
      for (int p = 0; p < len; p++) begin
         int b = p / 3;
         fs = send_fs && (p == 0);
         for (int n = 0; n < 4; n++) din[n] = wd[2*n + b/32][31 - b%32];
         @(posedge clk);
         @(negedge clk);
         #1;
         rx[191-p] = dout;
         if (chk_clk) begin
            if (bclk !== (p % 3 == 2) || ws !== (b >= 31 && b <= 62)) clk_err++;
         end
      end
      fs = 1'b0;
      sent_prev = pack24();
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      #1;
      check({bclk, ws, dout} === 3'b000, "R11", "outputs in reset",
            192'({bclk, ws, dout}), 192'd0);
      rst_n = 1'b1;
   endtask

   task automatic t_prelock;
      fill(32'h5A5A_1234);
      run_frame(1'b0, FR, 1'b0);
      check(rx === '0, "R8", "output before first pulse, frame 1", rx, '0);
      fill(32'hC3C3_8765);
      run_frame(1'b0, FR, 1'b0);
      check(rx === '0, "R8", "output before first pulse, frame 2", rx, '0);
   endtask

   task automatic t_lock;
      fill(32'h1357_9BDF);
      run_frame(1'b1, FR, 1'b1);
      check(rx === '0, "R8", "frame after first pulse is silent", rx, '0);
      check(clk_err == 0, "R1 R2", "bit clock and word clock shape",
            192'(clk_err), 192'd0);
   endtask

   task automatic t_stream;
      fill(32'h2468_ACE0);
      run_frame(1'b1, FR, 1'b1);
      check(rx === expect_now, "R3 R6 R7", "first captured frame one period later", rx, expect_now);
      fill(32'hFEDC_BA98);
      run_frame(1'b1, FR, 1'b1);
      check(rx === expect_now, "R3 R6 R7", "second frame", rx, expect_now);
      check(clk_err == 0, "R1 R2", "clock shape in stream", 192'(clk_err), 192'd0);
   endtask

   task automatic t_mapping;
      for (int s = 0; s < SLOTS; s++) wd[s] = '0;
      wd[5] = 32'hFFFF_FF00;      // line 2, right channel
      run_frame(1'b1, FR, 1'b1);
      fill(32'h0F0F_F0F0);
      run_frame(1'b1, FR, 1'b1);
      check(rx === (192'hFF_FFFF << (24 * (7 - 5))), "R4", "line 2 right lands in slot 5",
            rx, 192'hFF_FFFF << (24 * (7 - 5)));
   endtask

   task automatic t_trunc;
      for (int s = 0; s < SLOTS; s++) wd[s] = 32'h8000_00FF;
      run_frame(1'b1, FR, 1'b1);
      for (int s = 0; s < SLOTS; s++) wd[s] = 32'h0000_00FF;
      run_frame(1'b1, FR, 1'b1);
      check(rx === {8{24'h80_0000}}, "R5", "low byte discarded", rx, {8{24'h80_0000}});
      fill(32'h7777_1111);
      run_frame(1'b1, FR, 1'b1);
      check(rx === '0, "R5", "low-byte-only words give silence", rx, '0);
   endtask

   task automatic t_flywheel;
      fill(32'hA5A5_5A5A);
      run_frame(1'b0, FR, 1'b1);
      check(rx === expect_now, "R10", "frame without pulse still swaps", rx, expect_now);
      check(clk_err == 0, "R10", "clocks continue without pulse", 192'(clk_err), 192'd0);
      fill(32'h3141_5926);
      run_frame(1'b1, FR, 1'b1);
      check(rx === expect_now, "R10", "frame captured without pulse is sent", rx, expect_now);
   endtask

   task automatic t_early;
      fill(32'hDEAD_BEEF);
      run_frame(1'b1, 100, 1'b0);
      fill(32'h0BAD_CAFE);
      run_frame(1'b1, FR, 1'b1);
      check(rx === '0, "R9", "partial frame sent as silence", rx, '0);
      check(clk_err == 0, "R9", "clocks realigned by early pulse", 192'(clk_err), 192'd0);
      fill(32'h2718_2818);
      run_frame(1'b1, FR, 1'b1);
      check(rx === expect_now, "R9", "next full frame after realign", rx, expect_now);
   endtask

   initial begin
      sent_prev = '0;
      for (int s = 0; s < SLOTS; s++) wd[s] = '0;
      t_reset;
      t_prelock;
      t_lock;
      t_stream;
      t_mapping;
      t_trunc;
      t_flywheel;
      t_early;
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!finished) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule